// File: doc/BRIEF.md
# Synchronous Serial Character Receiver

This block takes characters from a single serial data line whose bit timing is given by a baud tick, a one-cycle enable supplied from outside and synchronous to the system clock. The line is sampled once per tick and never between ticks. A character opens with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and a stop bit closes the character. The receiver does not oversample the line and does not search for the middle of a bit. A low sample while idle starts a character at once.

Each finished character is placed in a holding register, and a ready flag is raised. The flag stays up until a read strobe. Three sticky error flags report problems. Overrun means a character arrived while the previous one was still unread. Parity error means the parity bit did not match the configured mode. Framing error means the stop bit was low while at least one data bit was high. A clear-status strobe drops all three error flags. Because of the framing rule, a character made only of zeros with a low stop bit, as seen during a line break, is delivered without a framing error.

Top module: `sync_char_rx`

## Requirements
- R1: The line is looked at only in cycles where `baud_tick` is 1. In the idle state, a low sample on a tick starts a character with no second confirmation sample. A low line without ticks, or a high line with ticks, starts nothing.
- R2: The next DATA_W ticks after the start sample collect the data bits, least significant bit first.
- R3: When `par_mode[2]` is 0, one parity sample follows the data bits. When `par_mode[2]` is 1, the stop sample follows the data bits directly.
- R4: On the stop-bit tick, the data goes to `rx_data`, and `rx_ready` is 1 from the next clock on. The receiver then goes back to idle and waits for a start bit.
- R5: A one-cycle pulse on `rd_strobe` clears `rx_ready` on the next clock and leaves `rx_data` unchanged. If a character completes in the same cycle, `rx_ready` stays 1.
- R6: If a character completes while `rx_ready` is 1 and no read happens in that cycle, `ovr_err` is set. The new character replaces the old one in `rx_data`.
- R7: Parity encoding of `par_mode`: 3'b000 means even, so the expected bit is the XOR of the data. 3'b001 means odd, so the expected bit is its inverse. 3'b010 means the bit must be 0, and 3'b011 means it must be 1. 3'b1xx means no parity. A mismatch with the received parity bit sets `par_err`.
- R8: `frm_err` is set only when the stop sample is 0 and at least one data bit is 1. An all-zero character with a low stop bit is still delivered, with no framing error.
- R9: `ovr_err`, `par_err` and `frm_err` stay set until a `clr_stat` pulse clears them on the next clock. A new error in that same cycle takes priority over the clear.
- R10: After reset, `rx_ready`, all error flags and `rx_data` are 0, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-sampling enable |
| rx_line | input | 1 | Serial data input, idle high |
| par_mode | input | 3 | Parity mode selector |
| rd_strobe | input | 1 | Read of the holding register, clears ready |
| clr_stat | input | 1 | Clears overrun, parity and framing flags |
| rx_data | output | DATA_W | Holding register |
| rx_ready | output | 1 | Holding register contains an unread character |
| ovr_err | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Sticky parity error flag |
| frm_err | output | 1 | Sticky framing error flag |

## Verification
The assertions assume three things about the inputs. `rx_line` is already synchronous to `clk`. `par_mode` does not change while a character is being received. `rd_strobe` and `clr_stat` are single-cycle pulses. The bench drives `rx_line` and `par_mode` only on falling edges between ticks. It changes the parity mode only while the receiver is idle, and it raises each strobe for exactly one clock. It sweeps every 8-bit data value under every parity mode, and it places both correct and deliberately wrong parity bits among them.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAR  = 2'd2,
    ST_STOP = 2'd3
  } srx_state_e;

  localparam logic [1:0] PM_EVEN = 2'd0;
  localparam logic [1:0] PM_ODD  = 2'd1;
  localparam logic [1:0] PM_ZERO = 2'd2;
  localparam logic [1:0] PM_ONE  = 2'd3;
endpackage

// File: rtl/srx_frame.sv
module srx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_line,
  input  logic              par_en,
  output logic [DATA_W-1:0] shift_q,
  output logic              pbit_q,
  output logic              frame_done
);
  import srx_pkg::*;
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  srx_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] shift_d;
  logic              pbit_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    shift_d    = shift_q;
    pbit_d     = pbit_q;
    frame_done = 1'b0;
    if (baud_tick) begin
      case (state_q)
        ST_IDLE: begin
          if (!rx_line) begin
            state_d = ST_DATA;
            cnt_d   = '0;
          end
        end
        ST_DATA: begin
          if (DATA_W > 1) shift_d = {rx_line, shift_q[DATA_W-1:1]};
          else            shift_d = rx_line;
          if (cnt_q == LAST) state_d = par_en ? ST_PAR : ST_STOP;
          else               cnt_d   = cnt_q + 1'b1;
        end
        ST_PAR: begin
          pbit_d  = rx_line;
          state_d = ST_STOP;
        end
        default: begin
          frame_done = 1'b1;
          state_d    = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      pbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      pbit_q  <= pbit_d;
    end
  end
endmodule

// File: rtl/srx_parity.sv
module srx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [2:0]        mode,
  input  logic              pbit,
  output logic              par_bad
);
  import srx_pkg::*;
  logic want;

  always_comb begin
    case (mode[1:0])
      PM_EVEN: want = ^data;
      PM_ODD:  want = ~^data;
      PM_ZERO: want = 1'b0;
      default: want = 1'b1;
    endcase
    par_bad = !mode[2] && (pbit != want);
  end
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_bad,
  input  logic              frm_bad,
  input  logic              rd_strobe,
  input  logic              clr_stat,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              ovr_q,
  output logic              pe_q,
  output logic              fe_q
);
  logic [DATA_W-1:0] data_d;
  logic ready_d, ovr_d, pe_d, fe_d;

  always_comb begin
    data_d  = load ? data_in : data_q;
    ready_d = ready_q;
    if (rd_strobe) ready_d = 1'b0;
    if (load)      ready_d = 1'b1;
    ovr_d = clr_stat ? 1'b0 : ovr_q;
    pe_d  = clr_stat ? 1'b0 : pe_q;
    fe_d  = clr_stat ? 1'b0 : fe_q;
    if (load && ready_q && !rd_strobe) ovr_d = 1'b1;
    if (load && par_bad)               pe_d  = 1'b1;
    if (load && frm_bad)               fe_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      data_q  <= data_d;
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
    end
  end
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_line,
  input  logic [2:0]        par_mode,
  input  logic              rd_strobe,
  input  logic              clr_stat,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              ovr_err,
  output logic              par_err,
  output logic              frm_err
);
  logic [DATA_W-1:0] shift_w;
  logic              pbit_w;
  logic              done_w;
  logic              par_bad_w;
  logic              frm_bad_w;

  srx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .rx_line    (rx_line),
    .par_en     (!par_mode[2]),
    .shift_q    (shift_w),
    .pbit_q     (pbit_w),
    .frame_done (done_w)
  );

  srx_parity #(.DATA_W(DATA_W)) u_par (
    .data    (shift_w),
    .mode    (par_mode),
    .pbit    (pbit_w),
    .par_bad (par_bad_w)
  );

  // stop sample low with some data bit high
  assign frm_bad_w = !rx_line && (|shift_w);

  srx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (done_w),
    .data_in   (shift_w),
    .par_bad   (par_bad_w),
    .frm_bad   (frm_bad_w),
    .rd_strobe (rd_strobe),
    .clr_stat  (clr_stat),
    .data_q    (rx_data),
    .ready_q   (rx_ready),
    .ovr_q     (ovr_err),
    .pe_q      (par_err),
    .fe_q      (frm_err)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe,
  input logic              clr_stat,
  input logic              done,
  input logic [DATA_W-1:0] frame_data,
  input logic              par_bad,
  input logic              frm_bad,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              ovr_err,
  input logic              par_err,
  input logic              frm_err
);
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rx_ready && rx_data == $past(frame_data)));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> (!rx_ready && $stable(rx_data)));

  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_ready && !rd_strobe) |=> ovr_err);

  assert_parity_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> $past(done && par_bad));

  assert_framing_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> $past(done && frm_bad));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_stat && (ovr_err || par_err || frm_err)) |=>
      ((ovr_err || !$past(ovr_err)) && (par_err || !$past(par_err)) &&
       (frm_err || !$past(frm_err))));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && !done) |=> (!ovr_err && !par_err && !frm_err));
endmodule

bind sync_char_rx srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_strobe  (rd_strobe),
  .clr_stat   (clr_stat),
  .done       (done_w),
  .frame_data (shift_w),
  .par_bad    (par_bad_w),
  .frm_bad    (frm_bad_w),
  .rx_data    (rx_data),
  .rx_ready   (rx_ready),
  .ovr_err    (ovr_err),
  .par_err    (par_err),
  .frm_err    (frm_err)
);

// File: tb/tb_sync_char_rx.sv
`timescale 1ns/1ps
module tb_sync_char_rx;
  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       rx_line;
  logic [2:0] par_mode;
  logic       rd_strobe;
  logic       clr_stat;
  logic [7:0] rx_data;
  logic       rx_ready, ovr_err, par_err, frm_err;

  int checks;
  int fails;

  sync_char_rx #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .par_mode(par_mode), .rd_strobe(rd_strobe), .clr_stat(clr_stat),
    .rx_data(rx_data), .rx_ready(rx_ready), .ovr_err(ovr_err),
    .par_err(par_err), .frm_err(frm_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge clk);
    rx_line   = b;
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic has_par, input logic pb, input logic sb);
    tick(1'b0);
    for (int i = 0; i < 8; i++) tick(d[i]);
    if (has_par) tick(pb);
    tick(sb);
    @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_stat = 1'b1;
    @(negedge clk); clr_stat = 1'b0;
  endtask

  function automatic logic want_par(input logic [2:0] m, input logic [7:0] d);
    case (m[1:0])
      2'd0: return ^d;
      2'd1: return ~^d;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; baud_tick = 1'b0; rx_line = 1'b1; par_mode = 3'b100;
    rd_strobe = 1'b0; clr_stat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready", rx_ready, 0);
    chk("R10 flags", {ovr_err, par_err, frm_err}, 0);
    chk("R10 data", rx_data, 0);

    // R1: low line without ticks, high line with ticks: nothing starts
    rx_line = 1'b0;
    repeat (40) @(negedge clk);
    rx_line = 1'b1;
    for (int i = 0; i < 12; i++) tick(1'b1);
    chk("R1 no start", rx_ready, 0);
    // a character sent now must still align (receiver still idle)
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R1 R2 aligned data", rx_data, 8'hA5);
    chk("R4 ready", rx_ready, 1);
    pulse_rd();
    chk("R5 ready cleared", rx_ready, 0);
    chk("R5 data kept", rx_data, 8'hA5);

    // R2 R3 R7 sweep: all modes, all values, alternating good/bad parity
    for (int m = 0; m < 5; m++) begin
      par_mode = (m == 4) ? 3'b100 : 3'(m);
      for (int v = 0; v < 256; v++) begin
        logic [7:0] d;
        logic bad, pb;
        d   = 8'(v);
        bad = (m != 4) && d[0];
        pb  = want_par(par_mode, d) ^ bad;
        send(d, m != 4, pb, 1'b1);
        chk("R2 R3 data", rx_data, d);
        chk("R7 parity flag", par_err, bad);
        chk("R4 no frame err", frm_err, 0);
        pulse_rd();
        if (bad) begin
          pulse_clr();
          chk("R9 clear", par_err, 0);
        end
      end
    end
    par_mode = 3'b100;

    // R8: all-zero with low stop -> delivered, no framing
    send(8'h00, 1'b0, 1'b0, 1'b0);
    chk("R8 zero delivered", rx_ready, 1);
    chk("R8 zero no frm", frm_err, 0);
    pulse_rd();
    send(8'h80, 1'b0, 1'b0, 1'b0);
    chk("R8 frm set", frm_err, 1);
    chk("R8 data", rx_data, 8'h80);
    pulse_rd();
    // R9 stays set across a clean character
    send(8'h3C, 1'b0, 1'b0, 1'b1);
    chk("R9 frm sticky", frm_err, 1);
    pulse_rd();
    pulse_clr();
    chk("R9 frm cleared", frm_err, 0);

    // R6 overrun
    send(8'h11, 1'b0, 1'b0, 1'b1);
    chk("R6 no ovr yet", ovr_err, 0);
    send(8'h22, 1'b0, 1'b0, 1'b1);
    chk("R6 ovr set", ovr_err, 1);
    chk("R6 replaced", rx_data, 8'h22);
    pulse_rd();
    send(8'h33, 1'b0, 1'b0, 1'b1);
    chk("R9 ovr sticky", ovr_err, 1);
    pulse_rd();
    pulse_clr();
    chk("R9 ovr cleared", ovr_err, 0);

    // R3: with parity on, stop sample comes one tick later
    par_mode = 3'b011;
    send(8'h5A, 1'b1, 1'b1, 1'b1);
    chk("R3 forced one ok", par_err, 0);
    chk("R3 data", rx_data, 8'h5A);
    pulse_rd();
    par_mode = 3'b100;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule